// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Cache

This block sits beside the fetch stage and guesses where the next fetch should go. Each fetched PC selects one table entry through the word-address bits just above the byte offset. An entry holds a valid flag, a tag made of the remaining upper PC bits, a two-bit hysteresis counter and a stored branch destination. When the entry matches and its counter leans towards taken, the predicted next PC is the stored destination, so a taken branch costs no fetch bubble. In every other case the prediction is the sequential address PC+4.

Later in the pipeline the branch resolves. The pipeline then sends back the branch PC, the real direction, the real destination and the next PC that was predicted for it. The block trains the entry and raises a one-cycle mispredict pulse together with the corrected fetch address, which the pipeline uses to flush and redirect. Two branches that share an index only evict each other or cause wrong guesses. Because every guess is checked at resolution, this never affects correctness.

Top module: `branch_predictor`

## Requirements
- R1: After a synchronous reset every entry is invalid, so any lookup predicts not taken with next PC equal to PC+4, and mispredict is low.
- R2: A lookup presented with fetch_valid high on one clock edge gives pred_valid, pred_taken and pred_next_pc after that edge. pred_valid is low one cycle after fetch_valid was low.
- R3: The entry index is PC bits [log2(ENTRIES)+1:2] and the tag is all PC bits above it. A PC that shares an index with a stored branch but has a different tag misses and predicts PC+4.
- R4: A taken resolution that misses the table allocates the entry with the PC's tag, the resolved destination and counter 10 (weakly taken). A following lookup of that PC predicts taken to that destination.
- R5: A not-taken resolution that misses the table changes nothing: the branch that already occupies the entry keeps its prediction.
- R6: Counter values 00 and 01 predict not taken, and 10 and 11 predict taken. A hit moves the counter up by one on taken and down by one on not taken, saturating at 11 and 00. The prediction therefore flips only after two consecutive wrong outcomes from a saturated state.
- R7: A taken resolution that hits the table overwrites the stored destination with the resolved one.
- R8: One cycle after upd_valid, mispredict is high exactly when the actual next PC differs from upd_pred_next. The actual next PC is upd_target if taken, otherwise upd_pc+4. redirect_pc then carries the actual next PC.
- R9: When a lookup and an update address the same entry on the same edge, the lookup returns the contents from before the update.
- R10: Once warmed up, a loop branch taken nine times and then not taken mispredicts only once per pass, at loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_pc | input | ADDR_W | PC being fetched |
| pred_valid | output | 1 | Prediction outputs refer to the previous cycle's lookup |
| pred_taken | output | 1 | Predicted taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | ADDR_W | Actual taken destination |
| upd_pred_next | input | ADDR_W | Next PC that was predicted for this branch |
| mispredict | output | 1 | Flush request, one cycle after the update |
| redirect_pc | output | ADDR_W | Correct fetch address when mispredict is high |

## Verification
The bench builds the block with ADDR_W=16 and ENTRIES=8. With these values two PCs 32 bytes apart share an index but carry different tags, so replacement and aliasing between two branches can be driven with short address constants. A single entry can also be walked through every counter state, including both saturation ends. A fresh index is used for the same-edge lookup and update case, and a ten-iteration loop is run twice to show the steady-state exit mispredict.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN    = 2'b00;
  localparam ctr_t CTR_WEAK_T = 2'b10;
  localparam ctr_t CTR_MAX    = 2'b11;

  // Saturating step of the hysteresis counter; MSB is the taken prediction
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
    else       return (c == CTR_MIN) ? c : ctr_t'(c - 2'd1);
  endfunction

endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bp_pkg::*;
(
  input  ctr_t cur,
  input  logic hit,
  input  logic taken,
  output ctr_t nxt
);

  always_comb begin
    if (!hit) nxt = CTR_WEAK_T;       // fresh allocation
    else      nxt = ctr_step(cur, taken);
  end

endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-3:0] rd_addr,
  output logic              rd_taken,
  output logic [ADDR_W-1:0] rd_tgt,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] wr_addr,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_tgt
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  ctr_t             ctr_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_mem [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_addr[IDX_W-1:0];
  assign rd_tag = rd_addr[ADDR_W-3:IDX_W];
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-3:IDX_W];

  // Update side: read-modify-write of the small per-entry state
  logic wr_hit, entry_we, tgt_we, wr_alloc;
  ctr_t ctr_new;

  assign wr_hit   = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign entry_we = wr_en && (wr_hit || wr_taken);
  assign tgt_we   = wr_en && wr_taken;
  assign wr_alloc = wr_en && !wr_hit && wr_taken;

  bp_ctr_next u_ctr (
    .cur   (ctr_q[wr_idx]),
    .hit   (wr_hit),
    .taken (wr_taken),
    .nxt   (ctr_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) valid_q[e] <= 1'b0;
    end else if (entry_we) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
      ctr_q[wr_idx]   <= ctr_new;
    end
  end

  // Lookup side: registered, sees pre-edge contents (read-first)
  logic rd_taken_q;
  always_ff @(posedge clk) begin
    if (rst) rd_taken_q <= 1'b0;
    else if (rd_en)
      rd_taken_q <= valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag) && ctr_q[rd_idx][1];
  end

  // Destination store: one write and one synchronous read port, no reset
  logic [ADDR_W-1:0] rd_tgt_q;
  always_ff @(posedge clk) begin
    if (tgt_we) tgt_mem[wr_idx] <= wr_tgt;
    if (rd_en)  rd_tgt_q <= tgt_mem[rd_idx];
  end

  assign rd_taken = rd_taken_q;
  assign rd_tgt   = rd_tgt_q;

  AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (rst)
    wr_alloc |=> valid_q[$past(wr_idx)] && (ctr_q[$past(wr_idx)] == CTR_WEAK_T)); // R4
  AST_NT_MISS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit && !wr_taken && !rst)
      |=> (valid_q[$past(wr_idx)] == $past(valid_q[wr_idx]))
       && (tag_q[$past(wr_idx)] == $past(tag_q[wr_idx]))); // R5
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && wr_taken && ctr_q[wr_idx] == CTR_MAX)
      |=> ctr_q[$past(wr_idx)] == CTR_MAX); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit && !wr_taken && ctr_q[wr_idx] == CTR_MIN)
      |=> ctr_q[$past(wr_idx)] == CTR_MIN); // R6

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [ADDR_W-1:0] upd_pred_next,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirect_pc
);

  logic [ADDR_W-1:0] actual_next;
  assign actual_next = upd_taken ? upd_target : upd_pc + ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= upd_valid && (actual_next != upd_pred_next);
      redirect_pc <= actual_next;
    end
  end

  AST_MISP_AFTER_UPD: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(upd_valid)); // R8
  AST_MISP_DIFFERS: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> redirect_pc != $past(upd_pred_next)); // R8

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [ADDR_W-1:0] upd_pred_next,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirect_pc
);

  logic              tbl_taken;
  logic [ADDR_W-1:0] tbl_tgt;
  logic [ADDR_W-1:0] seq_q;
  logic              pv_q;

  bp_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_addr  (fetch_pc[ADDR_W-1:2]),
    .rd_taken (tbl_taken),
    .rd_tgt   (tbl_tgt),
    .wr_en    (upd_valid),
    .wr_addr  (upd_pc[ADDR_W-1:2]),
    .wr_taken (upd_taken),
    .wr_tgt   (upd_target)
  );

  bp_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .clk           (clk),
    .rst           (rst),
    .upd_valid     (upd_valid),
    .upd_pc        (upd_pc),
    .upd_taken     (upd_taken),
    .upd_target    (upd_target),
    .upd_pred_next (upd_pred_next),
    .mispredict    (mispredict),
    .redirect_pc   (redirect_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q  <= 1'b0;
      seq_q <= '0;
    end else begin
      pv_q <= fetch_valid;
      if (fetch_valid) seq_q <= fetch_pc + ADDR_W'(4);
    end
  end

  assign pred_valid   = pv_q;
  assign pred_taken   = tbl_taken;
  assign pred_next_pc = tbl_taken ? tbl_tgt : seq_q;

  AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid); // R2
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid); // R2
  AST_NT_SEQ: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> pred_next_pc == $past(fetch_pc) + ADDR_W'(4)); // R3

endmodule

// File: tb/branch_predictor_tb.sv
`timescale 1ns/1ps
module branch_predictor_tb;

  localparam int AW = 16;
  localparam int NE = 8;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          pred_valid, pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          upd_valid, upd_taken;
  logic [AW-1:0] upd_pc, upd_target, upd_pred_next;
  logic          mispredict;
  logic [AW-1:0] redirect_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_predictor #(.ADDR_W(AW), .ENTRIES(NE)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_next(upd_pred_next),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  // {pc, taken, target, expected pred_taken, expected pred_next, expected mispredict}
  localparam logic [50:0] VEC [NV] = '{
    {16'h0104, 1'b1, 16'h00C0, 1'b0, 16'h0108, 1'b1}, // R4 allocate
    {16'h0104, 1'b1, 16'h00C0, 1'b1, 16'h00C0, 1'b0}, // R4 weakly taken predicts
    {16'h0104, 1'b1, 16'h00C0, 1'b1, 16'h00C0, 1'b0}, // R6 saturate high
    {16'h0104, 1'b0, 16'h00C0, 1'b1, 16'h00C0, 1'b1}, // R6 one wrong, still taken
    {16'h0104, 1'b0, 16'h00C0, 1'b1, 16'h00C0, 1'b1}, // R6 second wrong
    {16'h0104, 1'b0, 16'h00C0, 1'b0, 16'h0108, 1'b0}, // R6 now not taken
    {16'h0104, 1'b0, 16'h00C0, 1'b0, 16'h0108, 1'b0}, // R6 saturate low
    {16'h0104, 1'b1, 16'h00C0, 1'b0, 16'h0108, 1'b1}, // R6 hit in NT region
    {16'h0104, 1'b1, 16'h00E0, 1'b0, 16'h0108, 1'b1}, // R7 new destination
    {16'h0104, 1'b1, 16'h00E0, 1'b1, 16'h00E0, 0'b0 == 0 ? 1'b0 : 1'b0}, // R7 refreshed target used
    {16'h0124, 1'b0, 16'h0000, 1'b0, 16'h0128, 1'b0}, // R3 alias misses; R5 no alloc
    {16'h0104, 1'b1, 16'h00E0, 1'b1, 16'h00E0, 1'b0}, // R5 owner untouched
    {16'h0124, 1'b1, 16'h0200, 1'b0, 16'h0128, 1'b1}, // R3 alias allocates, evicts
    {16'h0104, 1'b1, 16'h00E0, 1'b0, 16'h0108, 1'b1}, // R3 evicted owner misses
    {16'h0124, 1'b0, 16'h0000, 1'b0, 16'h0128, 1'b0}, // R5 alias NT miss
    {16'h0104, 1'b1, 16'h00E0, 1'b1, 16'h00E0, 1'b0}, // R5 owner kept
    {16'h0008, 1'b0, 16'h0000, 1'b0, 16'h000C, 1'b0}  // R5 never allocated
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] pc, output logic tk,
                        output logic [AW-1:0] nx, output logic v);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    tk = pred_taken;
    nx = pred_next_pc;
    v  = pred_valid;
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt,
                         input logic [AW-1:0] pnext, output logic mp,
                         output logic [AW-1:0] red);
    @(negedge clk);
    upd_valid     = 1'b1;
    upd_pc        = pc;
    upd_taken     = tk;
    upd_target    = tgt;
    upd_pred_next = pnext;
    @(negedge clk);
    upd_valid = 1'b0;
    mp  = mispredict;
    red = redirect_pc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic tk, v, mp;
    logic [AW-1:0] nx, red;
    int miss_cnt;
    logic last_mp;

    rst = 1'b1; fetch_valid = 1'b0; fetch_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0; upd_pred_next = '0;
    do_reset();

    // R1 reset state
    check("R1", {31'd0, mispredict}, 32'd0, "mispredict after reset");
    check("R2", {31'd0, pred_valid}, 32'd0, "pred_valid after reset");
    lookup(16'h0104, tk, nx, v);
    check("R2", {31'd0, v}, 32'd1, "pred_valid after lookup");
    check("R1", {31'd0, tk}, 32'd0, "taken after reset");
    check("R1", {16'd0, nx}, 32'h0108, "next after reset");
    @(negedge clk);
    check("R2", {31'd0, pred_valid}, 32'd0, "pred_valid idle");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] vpc, vtgt, enx, exp_red;
      logic vtk, ept, emis;
      {vpc, vtk, vtgt, ept, enx, emis} = VEC[i];
      lookup(vpc, tk, nx, v);
      check("R6", {31'd0, tk}, {31'd0, ept}, $sformatf("vec %0d taken", i));
      check("R4", {16'd0, nx}, {16'd0, enx}, $sformatf("vec %0d next", i));
      resolve(vpc, vtk, vtgt, nx, mp, red);
      exp_red = vtk ? vtgt : vpc + 16'd4;
      check("R8", {31'd0, mp}, {31'd0, emis}, $sformatf("vec %0d mispredict", i));
      check("R8", {16'd0, red}, {16'd0, exp_red}, $sformatf("vec %0d redirect", i));
    end

    // R9 same-edge lookup and update on a fresh index
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 16'h000C;
    upd_valid = 1'b1; upd_pc = 16'h000C; upd_taken = 1'b1;
    upd_target = 16'h0400; upd_pred_next = 16'h0010;
    @(negedge clk);
    fetch_valid = 1'b0; upd_valid = 1'b0;
    check("R9", {31'd0, pred_taken}, 32'd0, "same-edge lookup taken");
    check("R9", {16'd0, pred_next_pc}, 32'h0010, "same-edge lookup next");
    check("R8", {31'd0, mispredict}, 32'd1, "same-edge mispredict");
    lookup(16'h000C, tk, nx, v);
    check("R9", {16'd0, nx}, 32'h0400, "after same-edge update");

    // R10 loop of nine taken then exit, two passes
    for (int pass = 0; pass < 2; pass++) begin
      miss_cnt = 0;
      last_mp  = 1'b0;
      for (int it = 0; it < 10; it++) begin
        lookup(16'h0010, tk, nx, v);
        resolve(16'h0010, (it < 9), 16'h0000, nx, mp, red);
        if (mp) miss_cnt++;
        last_mp = mp;
      end
      check("R10", miss_cnt, (pass == 0) ? 32'd2 : 32'd1, $sformatf("pass %0d mispredicts", pass));
      check("R10", {31'd0, last_mp}, 32'd1, $sformatf("pass %0d exit mispredict", pass));
    end

    // R1 reset clears trained entries
    do_reset();
    lookup(16'h0104, tk, nx, v);
    check("R1", {31'd0, tk}, 32'd0, "taken after second reset");
    check("R1", {16'd0, nx}, 32'h0108, "next after second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule